// File: doc/BRIEF.md
# Operand-Coherent Bus Arbiter

This block decides which of two masters, a CPU and a DMA engine, owns a shared external bus. Ownership is assigned by fixed priority, with the DMA engine above the CPU. A change of owner is only allowed at an operand boundary. Once a master holds the bus, it keeps it until every bus cycle of its current operand has ended, even if a higher-priority request arrives in the meantime.

Each master states how large its operand is and how wide the target port is. From these two values the arbiter works out how many bus cycles the operand needs. It then counts down one cycle for each completion pulse that comes from the current owner. Several things change where the operand boundaries fall:

- The CPU can hold a lock across a read-modify-write sequence, so the pair cannot be split.
- The DMA engine says whether it runs single-address or dual-address transfers, and in dual-address mode which half (read or write) is next.
- When the DMA source and destination ports differ in width, every access on the narrower side becomes its own arbitration unit.

Multi-operand CPU sequences are simply a series of operand requests. Arbitration may happen between any two of them.

Top module: `opc_bus_arbiter`

## Requirements
- R1: Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes; code 3 is treated as 4 bytes. An operand unit needs max(1, operand bytes / port bytes) bus cycles. `cyc_left` takes this value on the same rising edge at which the grant is given. While the bus has an owner, `cyc_left` is non-zero; while it has none, `cyc_left` is zero.
- R2: Each rising edge that samples `*_done` high from the current owner lowers `cyc_left` by one. A done pulse from the master that is not granted has no effect.
- R3: The grant outputs do not change while `cyc_left` is above 1. They also do not change while `cyc_left` is 1 and the owner's done is low. A request from the other master does not preempt an operand in progress.
- R4: At a boundary, or when the bus is idle, the DMA engine wins over the CPU. A boundary is the edge that samples the owner's done while `cyc_left` is 1. The new owner and its cycle count appear on that same edge.
- R5: If no request is present at a boundary, both grants go low and `cyc_left` becomes 0. While the bus is idle, any pending request is granted on the next rising edge.
- R6: If the CPU owns the bus and `cpu_lock` and `cpu_req` are both high at its boundary, the CPU keeps the grant and a new unit is loaded from the CPU's current sizes. This holds even when the DMA engine is requesting.
- R7: When `dma_dual` is 0 (single-address), the DMA cycle count uses `dma_src_port`, and `dma_dst_port` has no effect.
- R8: When `dma_dual` is 1, `dma_wr_half` picks the half: 0 = read, counted against `dma_src_port`; 1 = write, counted against `dma_dst_port`. Each half is a separate unit.
- R9: When `dma_dual` is 1 and the two port sizes differ, every unit on the narrower-port half is a single bus cycle. The wider-port half is counted as in R1.
- R10: During and right after reset, both grants are low and `cyc_left` is 0.
- R11: Sizes, port codes and half selection are sampled only at the start of a unit. Changing them in the middle of a unit does not alter the count in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | CPU requests the bus |
| cpu_opsz | input | SZ_W | CPU operand size code |
| cpu_port | input | SZ_W | CPU target port size code |
| cpu_lock | input | 1 | CPU read-modify-write lock |
| cpu_done | input | 1 | CPU bus cycle completed |
| dma_req | input | 1 | DMA requests the bus |
| dma_opsz | input | SZ_W | DMA operand size code |
| dma_src_port | input | SZ_W | DMA source port size code |
| dma_dst_port | input | SZ_W | DMA destination port size code |
| dma_dual | input | 1 | DMA dual-address mode |
| dma_wr_half | input | 1 | Next DMA unit is the write half |
| dma_done | input | 1 | DMA bus cycle completed |
| gnt_cpu | output | 1 | Bus granted to CPU |
| gnt_dma | output | 1 | Bus granted to DMA |
| cyc_left | output | CNT_W | Bus cycles left in the current unit |

## Verification
The assertions assume each master raises its done line at most once per clock. They also assume a master asserts its lock only together with its request. The countdown and hold properties rely on done pulses being the only thing that moves a unit forward. The stimulus changes every input on the falling edge. It only pulses done on behalf of a master that actually holds a unit, except in the one deliberate case where a non-owner pulse is applied to show that it is ignored.

// File: rtl/opc_arb_pkg.sv
package opc_arb_pkg;

    localparam int NUM_M = 2;
    localparam int M_CPU = 0;
    localparam int M_DMA = 1;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_CPU  = 2'd1,
        OWN_DMA  = 2'd2
    } owner_e;

endpackage

// File: rtl/opc_unit_cycles.sv
module opc_unit_cycles #(
    parameter int SZ_W   = 2,
    parameter int MAX_LG = 2,
    parameter int CNT_W  = 3
) (
    input  logic [SZ_W-1:0]  op_code,
    input  logic [SZ_W-1:0]  port_code,
    output logic [CNT_W-1:0] beats
);
    localparam logic [SZ_W-1:0] CODE_MAX = SZ_W'(MAX_LG);

    logic [SZ_W-1:0] op_c;
    logic [SZ_W-1:0] port_c;
    logic [SZ_W-1:0] diff;

    always_comb begin
        op_c   = (op_code   > CODE_MAX) ? CODE_MAX : op_code;
        port_c = (port_code > CODE_MAX) ? CODE_MAX : port_code;
        diff   = (op_c > port_c) ? (op_c - port_c) : '0;
        beats  = CNT_W'(1) << diff;
    end

endmodule

// File: rtl/opc_dma_half_sel.sv
module opc_dma_half_sel #(
    parameter int SZ_W   = 2,
    parameter int MAX_LG = 2
) (
    input  logic            dual,
    input  logic            wr_half,
    input  logic [SZ_W-1:0] src_port,
    input  logic [SZ_W-1:0] dst_port,
    output logic [SZ_W-1:0] port_eff,
    output logic            one_beat
);
    localparam logic [SZ_W-1:0] CODE_MAX = SZ_W'(MAX_LG);

    logic [SZ_W-1:0] src_c;
    logic [SZ_W-1:0] dst_c;

    always_comb begin
        src_c    = (src_port > CODE_MAX) ? CODE_MAX : src_port;
        dst_c    = (dst_port > CODE_MAX) ? CODE_MAX : dst_port;
        port_eff = (dual && wr_half) ? dst_c : src_c;
        // narrower side of a mismatched dual transfer is split per access
        one_beat = dual && (src_c != dst_c) &&
                   (wr_half ? (dst_c < src_c) : (src_c < dst_c));
    end

endmodule

// File: rtl/opc_fixed_prio.sv
module opc_fixed_prio
    import opc_arb_pkg::*;
(
    input  logic   hold_cpu,
    input  logic   cpu_req,
    input  logic   dma_req,
    output owner_e pick
);
    always_comb begin
        if (hold_cpu)      pick = OWN_CPU;
        else if (dma_req)  pick = OWN_DMA;
        else if (cpu_req)  pick = OWN_CPU;
        else               pick = OWN_NONE;
    end

endmodule

// File: rtl/opc_bus_arbiter.sv
module opc_bus_arbiter
    import opc_arb_pkg::*;
#(
    parameter int SZ_W   = 2,
    parameter int MAX_LG = 2,
    localparam int CNT_W = $clog2((1 << MAX_LG) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic [SZ_W-1:0]  cpu_opsz,
    input  logic [SZ_W-1:0]  cpu_port,
    input  logic             cpu_lock,
    input  logic             cpu_done,
    input  logic             dma_req,
    input  logic [SZ_W-1:0]  dma_opsz,
    input  logic [SZ_W-1:0]  dma_src_port,
    input  logic [SZ_W-1:0]  dma_dst_port,
    input  logic             dma_dual,
    input  logic             dma_wr_half,
    input  logic             dma_done,
    output logic             gnt_cpu,
    output logic             gnt_dma,
    output logic [CNT_W-1:0] cyc_left
);

    typedef struct packed {
        owner_e           owner;
        logic [CNT_W-1:0] left;
    } arb_state_t;

    arb_state_t st_d, st_q;

    // per-master cycle calculation
    logic [SZ_W-1:0]  op_v    [NUM_M];
    logic [SZ_W-1:0]  port_v  [NUM_M];
    logic [CNT_W-1:0] beats_v [NUM_M];
    logic [SZ_W-1:0]  dma_port_eff;
    logic             dma_one_beat;
    logic [CNT_W-1:0] dma_cyc;

    opc_dma_half_sel #(.SZ_W(SZ_W), .MAX_LG(MAX_LG)) u_half_sel (
        .dual     (dma_dual),
        .wr_half  (dma_wr_half),
        .src_port (dma_src_port),
        .dst_port (dma_dst_port),
        .port_eff (dma_port_eff),
        .one_beat (dma_one_beat)
    );

    always_comb begin
        op_v[M_CPU]   = cpu_opsz;
        port_v[M_CPU] = cpu_port;
        op_v[M_DMA]   = dma_opsz;
        port_v[M_DMA] = dma_port_eff;
    end

    for (genvar m = 0; m < NUM_M; m++) begin : g_cyc
        opc_unit_cycles #(.SZ_W(SZ_W), .MAX_LG(MAX_LG), .CNT_W(CNT_W)) u_cyc (
            .op_code   (op_v[m]),
            .port_code (port_v[m]),
            .beats     (beats_v[m])
        );
    end

    assign dma_cyc = dma_one_beat ? CNT_W'(1) : beats_v[M_DMA];

    // boundary detection and next owner
    logic   owner_done;
    logic   at_boundary;
    logic   hold_cpu;
    owner_e pick;

    always_comb begin
        owner_done  = ((st_q.owner == OWN_CPU) && cpu_done) ||
                      ((st_q.owner == OWN_DMA) && dma_done);
        at_boundary = (st_q.left == '0) ||
                      (owner_done && (st_q.left == CNT_W'(1)));
        hold_cpu    = (st_q.owner == OWN_CPU) && cpu_lock && cpu_req;
    end

    opc_fixed_prio u_prio (
        .hold_cpu (hold_cpu),
        .cpu_req  (cpu_req),
        .dma_req  (dma_req),
        .pick     (pick)
    );

    always_comb begin
        st_d = st_q;
        if (at_boundary) begin
            st_d.owner = pick;
            unique case (pick)
                OWN_CPU: st_d.left = beats_v[M_CPU];
                OWN_DMA: st_d.left = dma_cyc;
                default: st_d.left = '0;
            endcase
        end else if (owner_done) begin
            st_d.left = st_q.left - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{owner: OWN_NONE, left: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_cpu  = (st_q.owner == OWN_CPU);
    assign gnt_dma  = (st_q.owner == OWN_DMA);
    assign cyc_left = st_q.left;

    // assertions
    AST_OWNED_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_cpu || gnt_dma) == (cyc_left != '0)); // R1

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_left > CNT_W'(1) && owner_done) |=> ((cyc_left + CNT_W'(1)) == $past(cyc_left))); // R2

    AST_HOLD_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_left > CNT_W'(1)) |=> $stable({gnt_cpu, gnt_dma})); // R3

    AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_left == CNT_W'(1) && !owner_done) |=> $stable({gnt_cpu, gnt_dma})); // R3

    AST_DMA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_cpu && !gnt_dma && dma_req) |=> gnt_dma); // R4

    AST_NO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_cpu && !gnt_dma && (cpu_req || dma_req)) |=> (gnt_cpu || gnt_dma)); // R5

    AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_cpu && cpu_lock && cpu_req) |=> gnt_cpu); // R6

endmodule

// File: tb/opc_bus_arbiter_bench.sv
module opc_bus_arbiter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 0, cpu_lock = 0, cpu_done = 0;
    logic [1:0] cpu_opsz = 0, cpu_port = 0;
    logic       dma_req = 0, dma_dual = 0, dma_wr_half = 0, dma_done = 0;
    logic [1:0] dma_opsz = 0, dma_src_port = 0, dma_dst_port = 0;
    logic       gnt_cpu, gnt_dma;
    logic [2:0] cyc_left;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    opc_bus_arbiter u_opc_bus_arbiter (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_opsz(cpu_opsz), .cpu_port(cpu_port),
        .cpu_lock(cpu_lock), .cpu_done(cpu_done),
        .dma_req(dma_req), .dma_opsz(dma_opsz), .dma_src_port(dma_src_port),
        .dma_dst_port(dma_dst_port), .dma_dual(dma_dual),
        .dma_wr_half(dma_wr_half), .dma_done(dma_done),
        .gnt_cpu(gnt_cpu), .gnt_dma(gnt_dma), .cyc_left(cyc_left)
    );

    typedef struct {
        bit    gc;
        bit    gd;
        int    left;
        string tag;
    } exp_t;

    exp_t sb[$];

    // driver: queue what the next rising edge must produce
    task automatic tick(bit gc, bit gd, int left, string tag);
        exp_t e;
        e.gc = gc; e.gd = gd; e.left = left; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (gnt_cpu !== e.gc || gnt_dma !== e.gd || int'(cyc_left) != e.left) begin
                    errors++;
                    $display("FAIL %s: got gc=%0b gd=%0b left=%0d, expected gc=%0b gd=%0b left=%0d",
                             e.tag, gnt_cpu, gnt_dma, cyc_left, e.gc, e.gd, e.left);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (gnt_cpu !== 1'b0 || gnt_dma !== 1'b0 || cyc_left !== 3'd0) begin
            errors++;
            $display("FAIL R10: got gc=%0b gd=%0b left=%0d, expected 0 0 0", gnt_cpu, gnt_dma, cyc_left);
        end
        @(negedge clk);
        rst_n = 1'b1;
        tick(0, 0, 0, "R10");

        // CPU 4B operand on 1B port, DMA arrives mid-operand
        cpu_req = 1; cpu_opsz = 2; cpu_port = 0;
        dma_opsz = 2; dma_src_port = 2; dma_dst_port = 2; dma_dual = 0;
        tick(1, 0, 4, "R1");
        dma_req = 1; cpu_done = 1;
        tick(1, 0, 3, "R3");
        cpu_done = 0; dma_done = 1;          // non-owner pulse
        tick(1, 0, 3, "R2");
        dma_done = 0; cpu_done = 1;
        tick(1, 0, 2, "R2");
        tick(1, 0, 1, "R3");
        tick(0, 1, 1, "R4");
        cpu_done = 0; cpu_opsz = 1; cpu_port = 0; dma_req = 0; dma_done = 1;
        tick(1, 0, 2, "R4");
        dma_done = 0; cpu_done = 1;
        tick(1, 0, 1, "R2");
        cpu_req = 0;
        tick(0, 0, 0, "R5");
        cpu_done = 0;
        tick(0, 0, 0, "R5");
        cpu_req = 1; cpu_opsz = 0; cpu_port = 2;
        tick(1, 0, 1, "R1");
        cpu_req = 0; cpu_done = 1;
        tick(0, 0, 0, "R5");
        cpu_done = 0;

        // locked read-modify-write
        cpu_req = 1; cpu_lock = 1; cpu_opsz = 1; cpu_port = 0;
        tick(1, 0, 2, "R6");
        dma_req = 1; dma_opsz = 2; dma_src_port = 0; dma_dst_port = 2; dma_dual = 0;
        cpu_done = 1;
        tick(1, 0, 1, "R6");
        cpu_opsz = 2; cpu_port = 2;
        tick(1, 0, 1, "R6");
        cpu_lock = 0;
        tick(0, 1, 4, "R7");
        cpu_done = 0; cpu_req = 0; dma_done = 1; dma_opsz = 0;
        tick(0, 1, 3, "R11");
        tick(0, 1, 2, "R11");
        tick(0, 1, 1, "R11");
        dma_req = 0;
        tick(0, 0, 0, "R5");
        dma_done = 0; dma_opsz = 2;

        // dual-address, equal ports then mismatched
        dma_dual = 1; dma_src_port = 1; dma_dst_port = 1; dma_wr_half = 0; dma_req = 1;
        tick(0, 1, 2, "R8");
        dma_done = 1;
        tick(0, 1, 1, "R8");
        dma_wr_half = 1;
        tick(0, 1, 2, "R8");
        tick(0, 1, 1, "R8");
        dma_dst_port = 0;
        tick(0, 1, 1, "R9");
        cpu_req = 1; cpu_opsz = 2; cpu_port = 2; dma_req = 0;
        tick(1, 0, 1, "R9");
        dma_done = 0; dma_req = 1; dma_wr_half = 0; cpu_req = 0; cpu_done = 1;
        tick(0, 1, 2, "R9");
        cpu_done = 0; dma_req = 0; dma_done = 1;
        tick(0, 1, 1, "R9");
        tick(0, 0, 0, "R5");
        dma_done = 0; dma_dual = 0;

        // out-of-range size code clamps to 4 bytes
        cpu_req = 1; cpu_opsz = 3; cpu_port = 0;
        tick(1, 0, 4, "R1");
        cpu_req = 0; cpu_done = 1;
        tick(1, 0, 3, "R2");
        tick(1, 0, 2, "R2");
        tick(1, 0, 1, "R2");
        tick(0, 0, 0, "R5");
        cpu_done = 0;

        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule